// File: doc/BRIEF.md
# Framed Serial Receiver with Chain Output

This block is the serial front end of a small configurable device. A host drives an active-low frame select, a serial clock and a data line. While the frame select is low, the block shifts one bit into a 16-bit register on each falling edge of the serial clock, most significant bit first. When the frame select returns high, the block hands the word to the command logic that sits behind it. It does this only if the number of clock falls in the frame was a nonzero multiple of 16 and the device was not busy at any of those falls. Any other frame is dropped without a trace at the word port.

The bit leaving the top of the register is driven onto an open-drain style data output. Because of this, the output stream is the input stream delayed by 16 clocks, and several devices can share one frame select with the output of one wired to the input of the next. The command logic can also arm a 10-bit readback value. The next frame then shifts that value out in the low bits of the word, in place of the previous word. All serial pins are brought into the system clock domain through two-flop synchronizers and edge detectors, so the system clock must run at least four times faster than the serial clock.

Top module: `ser_chain_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `word_stb` and `sdo_pull_low` are 0.
- R2: A frame of exactly 16 clock falls produces a single `word_stb` pulse after the frame select rises. `word_cmd` equals bits 13..10 of the word and `word_data` equals bits 9..0, where the first bit received is bit 15. Bits 15..14 are not reported.
- R3: A frame whose fall count is a nonzero multiple of 16 (for example 32) is accepted and reports the last 16 bits received. A frame with any other count (0, 15, 17, 31, 33) produces no `word_stb`.
- R4: `word_stb` lasts exactly one system clock and appears only after a frame ends.
- R5: The output line carries the register's top bit, so each bit leaving a frame is the bit received 16 falls earlier. This holds across frame boundaries and after dropped frames.
- R6: Within a frame, the output changes only after a rising serial clock edge or at the start of the frame.
- R7: While the frame select is high, `sdo_pull_low` is 0, so the line is released.
- R8: A pulse on `rb_load` captures `rb_value`. The next frame then shifts out a word whose bits 9..0 are that value and whose bits 15..10 are 0. The value is used for one frame only.
- R9: A clock fall seen while `busy` is high is ignored: the register keeps its content, and the frame is not accepted even if its count is a multiple of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Frame select, active low, asynchronous |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| busy | input | 1 | Device busy; serial clock falls are ignored while high |
| rb_load | input | 1 | One-cycle strobe that arms a readback value |
| rb_value | input | 10 | Readback value for the next frame |
| word_stb | output | 1 | One-cycle pulse when a word has been accepted |
| word_cmd | output | 4 | Command field of the accepted word |
| word_data | output | 10 | Data field of the accepted word |
| sdo_pull_low | output | 1 | 1 pulls the serial output line low; 0 releases it |

## Verification
Assertions check on every cycle that the strobe is a single pulse following a frame-select rise, that the output line is released outside a frame, and that it holds steady between rising clock edges. They also check that a clock fall under busy leaves the register untouched and that each shift takes in the synchronized data bit. Only the bench's frame scenarios can show the end-to-end properties. These are the frame-length filter across 0, 15, 16, 17, 31, 32 and 33 falls, the 16-clock delay of the output across accepted and dropped frames, the one-frame life of a readback value, and the effect of a busy frame on the frame that follows it.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
    localparam int WORD_W = 16;
    localparam int CMD_W  = 4;
    localparam int DATA_W = 10;
    localparam int PAD_W  = WORD_W - CMD_W - DATA_W;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic word_t make_readback(input logic [DATA_W-1:0] v);
        word_t w;
        w.pad  = '0;
        w.cmd  = '0;
        w.data = v;
        return w;
    endfunction
endpackage

// File: rtl/sfe_sync.sv
`timescale 1ns/1ps
module sfe_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_edge.sv
`timescale 1ns/1ps
module sfe_edge
    import sfe_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  lvl,
    output edge_t ed
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign ed.rise = lvl & ~prev;
    assign ed.fall = ~lvl & prev;
endmodule

// File: rtl/sfe_framer.sv
`timescale 1ns/1ps
module sfe_framer
    import sfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_act,
    input  edge_t fs_ed,
    input  edge_t sck_ed,
    input  logic busy,
    output logic shift_en,
    output logic accept
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             taint;

    assign shift_en = frame_act & sck_ed.fall & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            full  <= 1'b0;
            taint <= 1'b0;
        end else if (fs_ed.fall) begin
            cnt   <= '0;
            full  <= 1'b0;
            taint <= 1'b0;
        end else if (frame_act && sck_ed.fall) begin
            if (busy) begin
                taint <= 1'b1;
            end else if (cnt == LAST) begin
                cnt  <= '0;
                full <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign accept = fs_ed.rise & full & (cnt == '0) & ~taint;

    // R3: once a whole word has been counted, only a new frame clears the flag
    p_full_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !fs_ed.fall) |=> full);
endmodule

// File: rtl/sfe_shifter.sv
`timescale 1ns/1ps
module sfe_shifter
    import sfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sdi_bit,
    input  logic              start,
    input  logic              stop,
    input  logic              use_rb,
    input  word_t             rb_word,
    input  logic              out_upd,
    output logic [WORD_W-1:0] shreg,
    output logic              sdo_pull_low
);
    logic sdo_q;
    logic drive_en;

    always_ff @(posedge clk) begin
        if (rst)                   shreg <= '0;
        else if (start && use_rb)  shreg <= rb_word;
        else if (shift_en)         shreg <= {shreg[WORD_W-2:0], sdi_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q    <= 1'b1;
            drive_en <= 1'b0;
        end else if (start) begin
            sdo_q    <= use_rb ? rb_word[WORD_W-1] : shreg[WORD_W-1];
            drive_en <= 1'b1;
        end else if (stop) begin
            drive_en <= 1'b0;
        end else if (out_upd) begin
            sdo_q <= shreg[WORD_W-1];
        end
    end

    assign sdo_pull_low = drive_en & ~sdo_q;

    // R5: every shift takes in the synchronized data bit at the bottom
    p_shift_in_r5: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> shreg[0] == $past(sdi_bit));
endmodule

// File: rtl/ser_chain_rx.sv
`timescale 1ns/1ps
module ser_chain_rx
    import sfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk_in,
    input  logic              sdi,
    input  logic              busy,
    input  logic              rb_load,
    input  logic [DATA_W-1:0] rb_value,
    output logic              word_stb,
    output logic [CMD_W-1:0]  word_cmd,
    output logic [DATA_W-1:0] word_data,
    output logic              sdo_pull_low
);
    logic [2:0] pins_raw, pins_s;
    logic       fs_s, sck_s, sdi_s, fs_act;
    edge_t      fs_ed, sck_ed;
    logic       shift_en, accept;
    logic       rb_pend;
    word_t      rb_word;
    logic [WORD_W-1:0] shreg;
    word_t      word_q;

    assign pins_raw = {sync_n, sclk_in, sdi};

    sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    assign fs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign sdi_s  = pins_s[0];
    assign fs_act = ~fs_s;

    sfe_edge #(.RST_VAL(1'b1)) u_fs_edge (
        .clk(clk), .rst(rst), .lvl(fs_s), .ed(fs_ed)
    );
    sfe_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst(rst), .lvl(sck_s), .ed(sck_ed)
    );

    sfe_framer u_framer (
        .clk(clk), .rst(rst), .frame_act(fs_act), .fs_ed(fs_ed), .sck_ed(sck_ed),
        .busy(busy), .shift_en(shift_en), .accept(accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_pend <= 1'b0;
            rb_word <= '0;
        end else if (rb_load) begin
            rb_pend <= 1'b1;
            rb_word <= make_readback(rb_value);
        end else if (fs_ed.fall) begin
            rb_pend <= 1'b0;
        end
    end

    sfe_shifter u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi_bit(sdi_s),
        .start(fs_ed.fall), .stop(fs_ed.rise), .use_rb(rb_pend), .rb_word(rb_word),
        .out_upd(fs_act & sck_ed.rise), .shreg(shreg), .sdo_pull_low(sdo_pull_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_stb <= 1'b0;
            word_q   <= '0;
        end else begin
            word_stb <= accept;
            if (accept) word_q <= shreg;
        end
    end

    assign word_cmd  = word_q.cmd;
    assign word_data = word_q.data;

    // R4: the strobe never lasts two cycles
    p_stb_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);
    // R2: a strobe only follows a frame-select rise
    p_stb_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> $past(fs_ed.rise));
    // R7: line released when frame select is high
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (fs_s && $past(fs_s)) |-> !sdo_pull_low);
    // R6: inside a frame the line only moves after a rising clock edge
    p_sdo_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fs_act && !sck_ed.rise && !fs_ed.fall && !fs_ed.rise) |=> $stable(sdo_pull_low));
    // R9: a clock fall while busy leaves the register untouched
    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && fs_act && sck_ed.fall && !rb_load) |=> $stable(shreg));
endmodule

// File: tb/ser_chain_rx_test.sv
`timescale 1ns/1ps
module ser_chain_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sdi = 1'b0;
    logic       busy = 1'b0;
    logic       rb_load = 1'b0;
    logic [9:0] rb_value = '0;
    logic       word_stb;
    logic [3:0] word_cmd;
    logic [9:0] word_data;
    logic       sdo_pull_low;

    ser_chain_rx uut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .sclk_in(sclk_in), .sdi(sdi),
        .busy(busy), .rb_load(rb_load), .rb_value(rb_value), .word_stb(word_stb),
        .word_cmd(word_cmd), .word_data(word_data), .sdo_pull_low(sdo_pull_low)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic m_q[$];
    bit   rb_armed = 1'b0;
    logic [9:0] rb_model = '0;

    bit   stb_win = 1'b0;
    int   stb_cnt = 0;
    logic [3:0] stb_cmd;
    logic [9:0] stb_data;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock monitor: any strobe outside a frame-end window is a miscompare
    always @(negedge clk) begin
        if (!rst && word_stb) begin
            stb_cnt++;
            stb_cmd  = word_cmd;
            stb_data = word_data;
            if (!stb_win) begin
                vectors++;
                miscompares++;
                $display("FAIL R4: actual strobe expected none at %0t", $time);
            end
        end
    end

    task automatic arm_rb(input logic [9:0] v);
        rb_value = v;
        rb_load  = 1'b1;
        #5;
        rb_load  = 1'b0;
        rb_armed = 1'b1;
        rb_model = v;
        #20;
    endtask

    task automatic frame(input string tag, input logic [63:0] bits, input int n, input bit with_busy);
        logic [15:0] w;
        bit ok;
        busy = with_busy;
        if (rb_armed) begin
            logic [15:0] rbw;
            rbw = {6'b0, rb_model};
            for (int i = 0; i < 16; i++) m_q[i] = rbw[15-i];
            rb_armed = 1'b0;
        end
        sync_n = 1'b0;
        #20;
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b1;
            sdi = bits[n-1-i];
            #20;
            if (!with_busy) chk({tag, " sdo bit"}, {31'b0, ~sdo_pull_low}, {31'b0, m_q[0]});
            sclk_in = 1'b0;
            if (!with_busy) begin
                void'(m_q.pop_front());
                m_q.push_back(bits[n-1-i]);
            end
            #20;
        end
        #20;
        stb_cnt = 0;
        stb_win = 1'b1;
        sync_n = 1'b1;
        #60;
        stb_win = 1'b0;
        busy = 1'b0;
        ok = (n > 0) && (n % 16 == 0) && !with_busy;
        chk({tag, " strobe count"}, stb_cnt, ok ? 1 : 0);
        if (ok) begin
            for (int i = 0; i < 16; i++) w[15-i] = m_q[i];
            chk({tag, " R2 cmd field"}, {28'b0, stb_cmd}, {28'b0, w[13:10]});
            chk({tag, " R2 data field"}, {22'b0, stb_data}, {22'b0, w[9:0]});
        end
        chk("R7 line released", {31'b0, sdo_pull_low}, 32'd0);
        #40;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_q.push_back(1'b0);
        #1;
        chk("R1 stb in reset", {31'b0, word_stb}, 32'd0);
        #24;
        rst = 1'b0;
        #5;
        chk("R1 stb after reset", {31'b0, word_stb}, 32'd0);
        chk("R1 line after reset", {31'b0, sdo_pull_low}, 32'd0);
        #20;
        frame("R2 R5 first word", 64'h2A5C, 16, 1'b0);
        frame("R2 R5 second word", 64'h1234, 16, 1'b0);
        frame("R3 R5 chained 32", 64'hABCD_1357, 32, 1'b0);
        frame("R3 short 15", 64'h5AA5, 15, 1'b0);
        frame("R3 R5 long 17", 64'h1_F00F, 17, 1'b0);
        frame("R3 R5 31 clocks", 64'h7123_4567, 31, 1'b0);
        frame("R3 R5 33 clocks", 64'h1_89AB_CDEF, 33, 1'b0);
        frame("R3 empty frame", 64'h0, 0, 1'b0);
        frame("R3 R6 recovery", 64'h3FC1, 16, 1'b0);
        arm_rb(10'h2C3);
        frame("R8 readback", 64'h0000, 16, 1'b0);
        frame("R8 readback spent", 64'h15A6, 16, 1'b0);
        frame("R9 busy frame", 64'hFFFF, 16, 1'b1);
        frame("R9 after busy", 64'h0842, 16, 1'b0);
        frame("R5 R9 final", 64'h8001, 16, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule